// File: doc/BRIEF.md
# Flowlet Path Selector

This block holds per-flow state for flowlet-style load balancing in a packet pipeline. For every packet it receives a flow hash, an arrival timestamp and a candidate path proposed by upstream logic. It keeps two things for each flow: when that flow was last seen and which path it used. If the flow has been idle for longer than a programmable gap, the packet starts a new flowlet and takes the candidate path. Otherwise the packet stays on the flow's saved path, so its packets are not reordered.

The block accepts one packet per clock. Its state update acts as a single atomic read-modify-write. A packet's result appears two clocks after it is presented. A packet that follows its own flow back-to-back sees the state that its predecessor has just written, through a forwarding path. Hashing of header fields and choosing the candidate path by load are done elsewhere.

Top module: `flowlet_path_select`

## Requirements
- R1: After reset `out_valid` is low and every flow entry is empty, so the first packet of any hash after reset starts a new flowlet.
- R2: A packet presented with `in_valid` high in cycle c produces exactly one result with `out_valid` high in cycle c+2. Results come out in arrival order, and a packet may be presented every cycle.
- R3: A packet whose flow entry is empty is sent on `in_path`, and `out_flowlet` is 1.
- R4: If the flow's entry is filled and the gap (`in_time` minus the stored time) is strictly greater than the threshold, the packet is sent on `in_path` and `out_flowlet` is 1.
- R5: If the gap is less than or equal to the threshold, the packet is sent on the flow's stored path and `out_flowlet` is 0. This includes a gap exactly equal to the threshold.
- R6: The gap is computed modulo 2^32, so a timestamp that has wrapped past zero still gives the small forward distance.
- R7: Every packet writes its own arrival time and its chosen path into its flow's entry. The gap is therefore always measured from the flow's most recent packet, not from the start of the flowlet.
- R8: A packet that follows a packet of the same hash in the very next cycle sees that packet's freshly written time and path.
- R9: The threshold, counted in timestamp ticks, resets to `DEF_GAP` (125000). A cycle with `cfg_we` high loads `cfg_gap`, and the new value applies to packets presented afterwards.
- R10: Packets of different hashes do not affect each other's entries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Load the gap threshold from `cfg_gap` |
| cfg_gap | input | 32 | New gap threshold in timestamp ticks |
| in_valid | input | 1 | A packet is presented this cycle |
| in_hash | input | 8 | Flow hash, indexes the flow table |
| in_time | input | 32 | Arrival timestamp in ticks |
| in_path | input | 4 | Candidate path for a new flowlet |
| out_valid | output | 1 | Result valid |
| out_path | output | 4 | Path chosen for the packet |
| out_flowlet | output | 1 | 1 when the packet started a new flowlet |

## Verification
The properties assume that timestamps within one flow never step backwards by less than 2^32 ticks. They also assume that `cfg_we` is not pulsed while a packet whose gap they judge is in flight, because the threshold used for the decision is the one held in the stage that makes it. The stimulus keeps each flow's timestamps rising. The only step backwards is a deliberate wrap through zero. Threshold writes are issued only after the pipeline has drained. Back-to-back runs on one hash, wrap cases and gaps exactly at the threshold are all driven in this way.

// File: rtl/flowlet_path_select.sv
module flowlet_path_select #(
  parameter int HASH_W = 8,
  parameter int TS_W = 32,
  parameter int PATH_W = 4,
  parameter int unsigned DEF_GAP = 125000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [TS_W-1:0]   cfg_gap,
  input  logic              in_valid,
  input  logic [HASH_W-1:0] in_hash,
  input  logic [TS_W-1:0]   in_time,
  input  logic [PATH_W-1:0] in_path,
  output logic              out_valid,
  output logic [PATH_W-1:0] out_path,
  output logic              out_flowlet
);
  localparam int DEPTH = 1 << HASH_W;

  logic [TS_W-1:0]   gap_q;
  logic [TS_W-1:0]   ts_mem [DEPTH];
  logic [PATH_W-1:0] path_mem [DEPTH];
  logic [DEPTH-1:0]  used_q;

  logic              s1_v, s1_hit;
  logic [HASH_W-1:0] s1_hash;
  logic [TS_W-1:0]   s1_time, s1_ts;
  logic [PATH_W-1:0] s1_sugg, s1_path;

  logic [TS_W-1:0]   s1_gap;
  logic              s1_new;
  logic [PATH_W-1:0] s1_sel;
  logic              fwd;

  assign s1_gap = s1_time - s1_ts;
  assign s1_new = !s1_hit || (s1_gap > gap_q);
  assign s1_sel = s1_new ? s1_sugg : s1_path;
  assign fwd    = s1_v && (s1_hash == in_hash);

  always_ff @(posedge clk) begin
    if (!rst_n) gap_q <= TS_W'(DEF_GAP);
    else if (cfg_we) gap_q <= cfg_gap;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) s1_v <= 1'b0;
    else s1_v <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      s1_hash <= in_hash;
      s1_time <= in_time;
      s1_sugg <= in_path;
      if (fwd) begin
        s1_ts   <= s1_time;
        s1_path <= s1_sel;
        s1_hit  <= 1'b1;
      end else begin
        s1_ts   <= ts_mem[in_hash];
        s1_path <= path_mem[in_hash];
        s1_hit  <= used_q[in_hash];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (s1_v) begin
      ts_mem[s1_hash]   <= s1_time;
      path_mem[s1_hash] <= s1_sel;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) used_q <= '0;
    else if (s1_v) used_q[s1_hash] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_path    <= '0;
      out_flowlet <= 1'b0;
    end else begin
      out_valid <= s1_v;
      if (s1_v) begin
        out_path    <= s1_sel;
        out_flowlet <= s1_new;
      end
    end
  end
endmodule

// File: rtl/flowlet_path_select_chk.sv
module flowlet_path_select_chk #(
  parameter int HASH_W = 8,
  parameter int TS_W = 32,
  parameter int PATH_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic              in_valid,
  input logic [HASH_W-1:0] in_hash,
  input logic [TS_W-1:0]   in_time,
  input logic [PATH_W-1:0] in_path,
  input logic              out_valid,
  input logic [PATH_W-1:0] out_path,
  input logic              out_flowlet,
  input logic [TS_W-1:0]   gap_q
);
  AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ##1 out_valid); // R2

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid, 2)); // R2

  AST_NEW_TAKES_SUGGESTED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_flowlet |-> out_path == $past(in_path, 2)); // R3

  AST_BTB_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && $past(in_valid) && !cfg_we && in_hash == $past(in_hash)
      && (in_time - $past(in_time)) <= gap_q
    |=> ##1 (!out_flowlet && out_path == $past(out_path))); // R8

  AST_BTB_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && $past(in_valid) && !cfg_we && in_hash == $past(in_hash)
      && (in_time - $past(in_time)) > gap_q
    |=> ##1 out_flowlet); // R4

  AST_OUT_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !$isunknown({out_path, out_flowlet})); // R2
endmodule

bind flowlet_path_select flowlet_path_select_chk #(
  .HASH_W(HASH_W), .TS_W(TS_W), .PATH_W(PATH_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .in_valid(in_valid),
  .in_hash(in_hash), .in_time(in_time), .in_path(in_path),
  .out_valid(out_valid), .out_path(out_path), .out_flowlet(out_flowlet),
  .gap_q(gap_q)
);

// File: tb/test_flowlet_path_select.sv
`timescale 1ns/1ps
module test_flowlet_path_select;
  logic clk = 0, rst_n = 0, cfg_we = 0, in_valid = 0;
  logic [31:0] cfg_gap = 0, in_time = 0;
  logic [7:0] in_hash = 0;
  logic [3:0] in_path = 0;
  logic out_valid, out_flowlet;
  logic [3:0] out_path;

  flowlet_path_select i_flowlet_path_select (.*);

  always #4 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  logic [31:0] m_ts [256];
  logic [3:0] m_path [256];
  logic m_used [256];
  logic [31:0] m_gap;

  logic [3:0] q_path [$];
  logic q_fl [$];
  int q_cyc [$];
  string q_tag [$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 256; i++) m_used[i] = 0;
    m_gap = 32'd125000;
  endtask

  task automatic send(input logic [7:0] h, input logic [31:0] t, input logic [3:0] p, input string tag);
    logic nf;
    logic [3:0] sel;
    @(negedge clk);
    in_valid = 1; in_hash = h; in_time = t; in_path = p;
    nf = !m_used[h] || ((t - m_ts[h]) > m_gap);
    sel = nf ? p : m_path[h];
    m_used[h] = 1; m_ts[h] = t; m_path[h] = sel;
    q_path.push_back(sel); q_fl.push_back(nf); q_cyc.push_back(cyc + 2); q_tag.push_back(tag);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 0;
    end
  endtask

  task automatic set_gap(input logic [31:0] g);
    idle(3);
    @(negedge clk); cfg_we = 1; cfg_gap = g;
    @(negedge clk); cfg_we = 0;
    m_gap = g;
  endtask

  task automatic do_reset();
    idle(3);
    rst_n = 0;
    repeat (3) @(negedge clk);
    check(out_valid == 0, "R1", "out_valid in reset", out_valid, 0);
    rst_n = 1;
    model_reset();
    @(negedge clk);
    check(out_valid == 0, "R1", "out_valid after reset", out_valid, 0);
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (q_path.size() == 0) begin
        check(0, "R2", "unexpected result", 1, 0);
      end else begin
        string tg;
        tg = q_tag.pop_front();
        check(cyc == q_cyc[0], "R2", "result cycle", cyc, q_cyc[0]);
        void'(q_cyc.pop_front());
        check(out_path == q_path[0], tg, "path", out_path, q_path[0]);
        void'(q_path.pop_front());
        check(out_flowlet == q_fl[0], tg, "flowlet", out_flowlet, q_fl[0]);
        void'(q_fl.pop_front());
      end
    end
  end

  initial begin
    #(8 * 200000);
    check(0, "WD", "watchdog expired", 0, 1);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    model_reset();
    do_reset();
    // R3 first packet, R5 small gap, R5 equal gap, R4 just over (default gap, R9)
    send(8'd5, 32'd100, 4'd3, "R3");
    idle(2);
    send(8'd5, 32'd200, 4'd7, "R5");
    idle(2);
    send(8'd5, 32'd125200, 4'd7, "R5_R9");
    idle(2);
    send(8'd5, 32'd250201, 4'd7, "R4");
    idle(2);
    // R6 wraparound
    send(8'd9, 32'hFFFF_FF00, 4'd2, "R3");
    idle(2);
    send(8'd9, 32'h0000_0050, 4'd6, "R6");
    idle(2);
    // R8 back-to-back same hash with default gap
    send(8'd20, 32'd1000, 4'd1, "R3");
    send(8'd20, 32'd1001, 4'd9, "R8");
    send(8'd20, 32'd1002, 4'd10, "R8");
    idle(3);
    // R9 smaller threshold, R8 forwarding across a switch
    set_gap(32'd10);
    send(8'd20, 32'd2000, 4'd4, "R4");
    send(8'd20, 32'd2005, 4'd8, "R8");
    send(8'd20, 32'd2020, 4'd8, "R8");
    send(8'd20, 32'd2021, 4'd11, "R8");
    send(8'd20, 32'd2031, 4'd12, "R5");
    send(8'd20, 32'd2042, 4'd13, "R4");
    idle(3);
    // R7 chained short gaps keep the path
    send(8'd30, 32'd0, 4'd1, "R3");
    idle(1);
    send(8'd30, 32'd8, 4'd5, "R7");
    idle(1);
    send(8'd30, 32'd16, 4'd5, "R7");
    send(8'd30, 32'd24, 4'd5, "R7");
    idle(3);
    // R10 interleaved flows
    send(8'd40, 32'd5000, 4'd2, "R10");
    send(8'd41, 32'd5001, 4'd3, "R10");
    send(8'd40, 32'd5003, 4'd7, "R10");
    send(8'd41, 32'd5100, 4'd6, "R10");
    send(8'd40, 32'd5005, 4'd9, "R10");
    send(8'd41, 32'd5105, 4'd1, "R10");
    idle(3);
    // R1 second reset clears entries and threshold
    do_reset();
    send(8'd5, 32'd250210, 4'd14, "R1");
    idle(2);
    send(8'd5, 32'd300000, 4'd2, "R9");
    idle(2);
    send(8'd255, 32'd7, 4'd15, "R1");
    send(8'd0, 32'd7, 4'd0, "R10");
    idle(6);
    check(q_path.size() == 0, "R2", "pending results", q_path.size(), 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule